// File: doc/BRIEF.md
# Watchdog Timer with Timed Change Protection

This block is a watchdog timer that asks for a system reset when software stops restarting it in time. The timeout is a power of two of the watchdog clock, picked by a 3-bit prescale field. Software can change the enable and prescale settings only through a two-write unlock sequence. The second write must arrive within a short window after the first. A stray single write therefore cannot stop or slow the watchdog.

A strap input selects an always-on safety level. In that level the watchdog runs from reset and cannot be disabled. A sticky flag records each watchdog timeout. While the flag is set, the watchdog also stays enabled, so software has to clear the flag before it can turn the watchdog off.

The control register layout is: bits 2:0 prescale, bit 3 enable, bit 4 change-enable, bits 7:5 always 0. The status register holds the sticky timeout flag in bit 0, and its other bits read 0. `wrSel` selects the register: 0 for control, 1 for status.

Top module: `wdog_locked`

## Requirements
- R1: A control write with bit 4 and bit 3 both set opens the change window. From the next cycle, control bit 4 reads 1, and enable and prescale do not change.
- R2: A control write with bit 4 clear that lands 1 to 4 cycles after the unlock write loads prescale from bits 2:0 and enable from bit 3, and closes the window (bit 4 reads 0).
- R3: After 4 cycles with no follow-up write, the window closes by itself and bit 4 reads 0. A follow-up write 5 or more cycles after the unlock write changes nothing.
- R4: Control writes outside an open window change nothing. A control write with bit 4 set and bit 3 clear does not open a window.
- R5: With the safety strap high, control bit 3 always reads 1. In that level, a follow-up write ignores the enable bit and still applies the prescale bits.
- R6: While the timeout flag is set, the watchdog stays enabled and a follow-up write cannot clear enable. A status write with bit 0 = 0 clears the flag. If a timeout and a clear happen in the same cycle, the timeout wins.
- R7: When the watchdog is enabled and 2^(BASE_EXP+n) cycles pass after a restart strobe (n = prescale), `resetReq` is high for exactly one cycle. The flag (status bit 0) sets in that same cycle.
- R8: The restart strobe clears the timeout counter to zero. A disabled watchdog never raises `resetReq`.
- R9: After reset with the strap low, control reads 0x00, status reads 0x00 and `resetReq` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Watchdog and register clock |
| rstN | input | 1 | Active-low asynchronous reset |
| safetyLock | input | 1 | Always-on safety level strap, static after reset |
| wrEn | input | 1 | Register write strobe |
| wrSel | input | 1 | Register select: 0 control, 1 status |
| wrData | input | 8 | Register write data |
| restart | input | 1 | Watchdog restart strobe |
| ctrlRead | output | 8 | Control register readback |
| statusRead | output | 8 | Status register readback |
| resetReq | output | 1 | One-cycle watchdog reset request |

## Verification
The assertions assume that `safetyLock` is held steady while out of reset. They also assume that a single cycle never carries both a control write and a status write, which holds because there is only one write port. The bench changes the strap only while reset is held. It drives at most one write or restart per cycle on the falling edge. Its random timeout runs use prescale values whose periods stay well below the run limit.

// File: rtl/wdog_pkg.sv
package wdog_pkg;
  localparam int PRE_W    = 3;
  localparam int PRE_LSB  = 0;
  localparam int EN_BIT   = 3;
  localparam int CE_BIT   = 4;
  localparam int FLAG_BIT = 0;

  typedef struct packed {
    logic             applyHit;
    logic [PRE_W-1:0] newPrescale;
    logic             newEnable;
    logic             clearFlag;
  } ctrlStrobe_t;
endpackage

// File: rtl/wdog_ctrl.sv
module wdog_ctrl
  import wdog_pkg::*;
#(
  parameter int WINDOW = 4
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        wrEn,
  input  logic        wrSel,
  input  logic [7:0]  wrData,
  output ctrlStrobe_t strb,
  output logic        changeEn
);
  localparam int WIN_W = $clog2(WINDOW + 1);

  logic [WIN_W-1:0] winLeft;
  logic ctrlWr, unlockHit;

  assign ctrlWr    = wrEn && !wrSel;
  assign unlockHit = ctrlWr && wrData[CE_BIT] && wrData[EN_BIT];

  always_comb begin
    strb.applyHit    = ctrlWr && !wrData[CE_BIT] && (winLeft != '0);
    strb.newPrescale = wrData[PRE_LSB +: PRE_W];
    strb.newEnable   = wrData[EN_BIT];
    strb.clearFlag   = wrEn && wrSel && !wrData[FLAG_BIT];
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                winLeft <= '0;
    else if (unlockHit)       winLeft <= WIN_W'(WINDOW);
    else if (strb.applyHit)   winLeft <= '0;
    else if (winLeft != '0)   winLeft <= winLeft - 1'b1;
  end

  assign changeEn = (winLeft != '0);

  // R3: a closed window stays closed unless a fresh unlock write arrives
  assert_window_closed_R3: assert property (@(posedge clk) disable iff (!rstN)
    (!changeEn && !unlockHit) |=> !changeEn);
  // R2: an accepted follow-up write closes the window
  assert_apply_closes_R2: assert property (@(posedge clk) disable iff (!rstN)
    strb.applyHit |=> !changeEn);
  // R1: an unlock write opens the window
  assert_unlock_opens_R1: assert property (@(posedge clk) disable iff (!rstN)
    unlockHit |=> changeEn);
endmodule

// File: rtl/wdog_datapath.sv
module wdog_datapath
  import wdog_pkg::*;
#(
  parameter int BASE_EXP = 11
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             safetyLock,
  input  logic             restart,
  input  ctrlStrobe_t      strb,
  output logic [PRE_W-1:0] prescale,
  output logic             effEnable,
  output logic             flag,
  output logic             resetReq
);
  localparam int CW = BASE_EXP + (1 << PRE_W);

  logic          enableReg;
  logic [CW-1:0] count, lastCount;
  logic          hit;

  assign effEnable = enableReg || safetyLock || flag;
  assign lastCount = ({{(CW-1){1'b0}}, 1'b1} << (CW'(BASE_EXP) + CW'(prescale))) - CW'(1);
  assign hit       = effEnable && !restart && (count >= lastCount);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      prescale  <= '0;
      enableReg <= 1'b0;
    end else if (strb.applyHit) begin
      prescale  <= strb.newPrescale;
      enableReg <= strb.newEnable || safetyLock || flag;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                   count <= '0;
    else if (!effEnable || restart || hit) count <= '0;
    else                         count <= count + 1'b1;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      flag     <= 1'b0;
      resetReq <= 1'b0;
    end else begin
      resetReq <= hit;
      if (hit)                 flag <= 1'b1;
      else if (strb.clearFlag) flag <= 1'b0;
    end
  end

  // R6: a follow-up write under the flag or the safety level keeps enable set
  assert_forced_on_R6: assert property (@(posedge clk) disable iff (!rstN)
    (strb.applyHit && (safetyLock || flag)) |=> enableReg);
  // R7: the reset request is a single-cycle pulse
  assert_pulse_once_R7: assert property (@(posedge clk) disable iff (!rstN)
    resetReq |=> !resetReq);
  // R7: the sticky flag is set whenever a reset is requested
  assert_flag_with_req_R7: assert property (@(posedge clk) disable iff (!rstN)
    resetReq |-> flag);
  // R8: the restart strobe clears the counter
  assert_restart_clears_R8: assert property (@(posedge clk) disable iff (!rstN)
    restart |=> (count == '0));
  // R8: a disabled watchdog never requests a reset
  assert_idle_quiet_R8: assert property (@(posedge clk) disable iff (!rstN)
    !effEnable |=> !resetReq);
endmodule

// File: rtl/wdog_locked.sv
module wdog_locked
  import wdog_pkg::*;
#(
  parameter int BASE_EXP = 11,
  parameter int WINDOW   = 4
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       safetyLock,
  input  logic       wrEn,
  input  logic       wrSel,
  input  logic [7:0] wrData,
  input  logic       restart,
  output logic [7:0] ctrlRead,
  output logic [7:0] statusRead,
  output logic       resetReq
);
  ctrlStrobe_t      strb;
  logic             changeEn, effEnable, flag;
  logic [PRE_W-1:0] prescale;

  wdog_ctrl #(.WINDOW(WINDOW)) u_ctrl (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrSel(wrSel), .wrData(wrData),
    .strb(strb), .changeEn(changeEn)
  );

  wdog_datapath #(.BASE_EXP(BASE_EXP)) u_dp (
    .clk(clk), .rstN(rstN), .safetyLock(safetyLock), .restart(restart),
    .strb(strb), .prescale(prescale), .effEnable(effEnable), .flag(flag),
    .resetReq(resetReq)
  );

  always_comb begin
    ctrlRead = '0;
    ctrlRead[PRE_LSB +: PRE_W] = prescale;
    ctrlRead[EN_BIT] = effEnable;
    ctrlRead[CE_BIT] = changeEn;
    statusRead = '0;
    statusRead[FLAG_BIT] = flag;
  end

  // R5: the safety level keeps the watchdog enabled
  assert_safety_on_R5: assert property (@(posedge clk) disable iff (!rstN)
    safetyLock |-> ctrlRead[EN_BIT]);
endmodule

// File: tb/test_wdog_locked.sv
module test_wdog_locked;
  localparam int CLK_PERIOD = 10;
  localparam int BASE_EXP   = 3;

  logic clk = 0, rstN = 0, safetyLock = 0, wrEn = 0, wrSel = 0, restart = 0;
  logic [7:0] wrData = 0;
  logic [7:0] ctrlRead, statusRead;
  logic resetReq;
  int checks = 0, errors = 0;
  bit done = 0;

  wdog_locked #(.BASE_EXP(BASE_EXP), .WINDOW(4)) i_wdog_locked (
    .clk(clk), .rstN(rstN), .safetyLock(safetyLock), .wrEn(wrEn), .wrSel(wrSel),
    .wrData(wrData), .restart(restart), .ctrlRead(ctrlRead),
    .statusRead(statusRead), .resetReq(resetReq)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic int expLimit(int n);
    return 1 << (BASE_EXP + n);
  endfunction

  function automatic logic [7:0] expCtrl(bit ce, bit en, int n);
    return {3'b000, ce, en, 3'(n)};
  endfunction

  task automatic check(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic doReset(bit strap);
    @(negedge clk); rstN = 0; safetyLock = strap;
    repeat (3) @(negedge clk);
    rstN = 1;
    @(negedge clk);
  endtask

  task automatic writeReg(bit sel, logic [7:0] d);
    wrEn = 1; wrSel = sel; wrData = d;
    @(negedge clk);
    wrEn = 0; wrSel = 0; wrData = 0;
  endtask

  task automatic kick();
    restart = 1;
    @(negedge clk);
    restart = 0;
  endtask

  // unlock, then follow-up write landing gap edges after the unlock edge
  task automatic seqWrite(int gap, logic [7:0] d);
    writeReg(0, 8'h18);
    repeat (gap - 1) @(negedge clk);
    writeReg(0, d);
  endtask

  task automatic measureTimeout(int n);
    int cnt = 0;
    kick();
    while (!resetReq && cnt < 5000) begin
      @(negedge clk);
      cnt++;
    end
    check("R7 timeout length", cnt, expLimit(n));
    check("R7 flag set with request", statusRead, 8'h01);
    @(negedge clk);
    check("R7 request lasts one cycle", resetReq, 0);
  endtask

  initial begin
    repeat (150000) @(negedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: run did not finish");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5eed_1234));
    doReset(0);
    check("R9 reset ctrl", ctrlRead, 8'h00);
    check("R9 reset status", statusRead, 8'h00);
    check("R9 reset request", resetReq, 0);

    // R4: writes with no window open
    writeReg(0, 8'h0D);
    check("R4 no-window write ignored", ctrlRead, 8'h00);
    writeReg(0, 8'h10);
    check("R4 ce without en opens nothing", ctrlRead, 8'h00);
    repeat (100) @(negedge clk);
    check("R8 disabled never resets", statusRead, 8'h00);

    // R1 / R2: update at the last legal cycle
    writeReg(0, 8'h18);
    check("R1 window open after unlock", ctrlRead, expCtrl(1, 0, 0));
    repeat (3) @(negedge clk);
    writeReg(0, 8'h0D);
    check("R2 follow-up at cycle 4 applied", ctrlRead, expCtrl(0, 1, 5));

    // R3: follow-up at cycle 5 rejected
    kick();
    writeReg(0, 8'h18);
    repeat (3) @(negedge clk);
    check("R3 window still open at cycle 3", ctrlRead, expCtrl(1, 1, 5));
    @(negedge clk);
    check("R3 window closed by itself", ctrlRead, expCtrl(0, 1, 5));
    writeReg(0, 8'h00);
    check("R3 follow-up at cycle 5 rejected", ctrlRead, expCtrl(0, 1, 5));

    // R7 + R6: timeout then flag holds enable
    seqWrite(1, 8'h09);
    measureTimeout(1);
    seqWrite(2, 8'h00);
    check("R6 flag keeps enable on", ctrlRead, expCtrl(0, 1, 0));
    writeReg(1, 8'h00);
    check("R6 status write clears flag", statusRead, 8'h00);
    check("R6 enable still on after clear", ctrlRead, expCtrl(0, 1, 0));
    kick();
    seqWrite(3, 8'h00);
    check("R6 disable after flag cleared", ctrlRead, 8'h00);

    // random timeouts and restart intervals
    for (int it = 0; it < 20; it++) begin
      int n = $urandom % 4;
      int gap = 1 + ($urandom % 4);
      int seen = 0;
      kick();
      seqWrite(gap, expCtrl(0, 1, n));
      check("R2 random follow-up applied", ctrlRead, expCtrl(0, 1, n));
      measureTimeout(n);
      writeReg(1, 8'hFE);
      check("R6 random flag clear", statusRead, 8'h00);
      for (int k = 0; k < 5; k++) begin
        int w = 1 + ($urandom % (expLimit(n) - 4));
        kick();
        for (int c = 0; c < w; c++) begin
          @(negedge clk);
          if (resetReq) seen++;
        end
      end
      check("R8 restarts prevent reset", seen, 0);
    end
    kick();
    seqWrite(1, 8'h00);
    check("R2 disable at end of random run", ctrlRead, 8'h00);

    // R5: safety level
    doReset(1);
    check("R5 enable reads 1 from reset", ctrlRead[3], 1);
    seqWrite(2, 8'h05);
    check("R5 enable ignored, prescale applied", ctrlRead & 8'h1F, expCtrl(0, 1, 5));
    seqWrite(4, 8'h00);
    check("R5 cannot clear enable", ctrlRead & 8'h1F, expCtrl(0, 1, 0));

    doReset(0);
    check("R9 reset after safety run", ctrlRead, 8'h00);

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule